// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a watchdog timer that hangs off a simple register bus. Once software enables it, a down-counter runs from a power-of-two period selected by a 4-bit range code. Software proves it is still alive by writing one exact key word to the restart register. Any other value written there does nothing. If the count runs out, the block responds in one of two ways, chosen by a mode bit. It can drive a fixed-length system-reset pulse at once, or it can first raise a level interrupt and give software one more full period before the reset pulse.

There are two range codes. The first load after enabling uses the "initial" code, which allows a longer boot-time window. Every load after that, whether from a kick or from an automatic reload, uses the "normal" code. The enable bit and the mode bit lock once the watchdog is running. Only the block reset stops it again.

Register map (byte offsets): control at 0x00 (bit 0 enable, bit 1 mode: 0 = reset at once, 1 = interrupt first), range at 0x04 (bits 3:0 normal code, bits 7:4 initial code), restart at 0x0C. A code `i` selects a period of 2^(BASE_SHIFT+i) clock cycles. BASE_SHIFT defaults to 16.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, the control and range registers read as 0, and `irq` and `sys_rst` are low.
- R2: A read strobe returns data on `bus_rdata` one cycle after the strobe edge. Control reads as {30'b0, mode, enable}, and range reads back its low 8 bits with bits 31:8 as zero.
- R3: A control write that sets bit 0 while disabled loads the initial period. The first expiry takes effect exactly 2^(BASE_SHIFT+initial code) edges after that write edge.
- R4: After an expiry, the counter reloads with the normal period, so the next expiry comes 2^(BASE_SHIFT+normal code) edges later.
- R5: Writing the full 32-bit word 0x00000076 to offset 0x0C while enabled reloads the normal period at that edge, cancels the pending expiry, and clears `irq`.
- R6: Any other value written to offset 0x0C is ignored, and the expiry time stays the same.
- R7: Once enabled, writes to the control register are ignored. Enable and mode keep their values until the block reset.
- R8: In reset mode (bit 1 = 0), every expiry drives `sys_rst` high for exactly PULSE_W cycles, starting at the expiry edge.
- R9: In interrupt mode (bit 1 = 1), an expiry with no interrupt pending raises `irq` and leaves `sys_rst` low. An expiry while `irq` is still high starts the reset pulse.
- R10: While disabled, the block never raises `irq` or `sys_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (4) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Level interrupt after a first expiry in interrupt mode |
| sys_rst | output | 1 | System-reset pulse, PULSE_W cycles long |

## Verification
The bench counts the exact edge of each expiry. A counter that loads P instead of P-1, or that uses the normal code on the first load, lands one edge or a whole period off. It writes near-miss keys, including the key with a stray upper bit set; a comparison on only the low byte would then push the expiry back. In interrupt mode it checks that the first expiry leaves `sys_rst` low and the second starts the pulse, and that a kick clears `irq`. It also rewrites control after enabling and reads it back, so an enable that software can clear shows up as a wrong value.

// File: rtl/wdt_keyed_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the keyed watchdog.
// Assumes byte-addressed 32-bit registers on a 4-bit offset.
package wdt_keyed_pkg;
    localparam int unsigned OFF_CTRL    = 'h0;
    localparam int unsigned OFF_RANGE   = 'h4;
    localparam int unsigned OFF_RESTART = 'hC;
    localparam logic [31:0] KICK_KEY    = 32'h0000_0076;
    typedef logic [3:0] range_code_t;
endpackage

// File: rtl/wdt_keyed_regs.sv
`timescale 1ns/1ps
// Register file: decodes the bus, holds control and range, and produces the
// start and kick strobes. Assumes single-cycle write/read strobes.
module wdt_keyed_regs
    import wdt_keyed_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              en,
    output logic              mode,
    output range_code_t       code_norm,
    output range_code_t       code_init,
    output logic              start,
    output logic              kick
);
    localparam int RANGE_W = 2 * $bits(range_code_t);

    logic               sel_ctrl, sel_range, sel_restart;
    logic [RANGE_W-1:0] range_q;

    // Address decode.
    always_comb begin
        sel_ctrl    = (bus_addr == ADDR_W'(OFF_CTRL));
        sel_range   = (bus_addr == ADDR_W'(OFF_RANGE));
        sel_restart = (bus_addr == ADDR_W'(OFF_RESTART));
    end

    // Strobes for the counter: enabling write and valid key write.
    always_comb begin
        start = bus_wr && sel_ctrl && bus_wdata[0] && !en;
        kick  = bus_wr && sel_restart && (bus_wdata == DATA_W'(KICK_KEY)) && en;
    end

    // Control bits, locked once enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en   <= 1'b0;
            mode <= 1'b0;
        end else if (bus_wr && sel_ctrl && !en) begin
            en   <= bus_wdata[0];
            mode <= bus_wdata[1];
        end
    end

    // Range codes, writable at any time, used at the next load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            range_q <= '0;
        end else if (bus_wr && sel_range) begin
            range_q <= bus_wdata[RANGE_W-1:0];
        end
    end

    assign code_norm = range_q[3:0];
    assign code_init = range_q[7:4];

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            if (sel_ctrl)       bus_rdata <= DATA_W'({mode, en});
            else if (sel_range) bus_rdata <= DATA_W'(range_q);
            else                bus_rdata <= '0;
        end
    end
endmodule

// File: rtl/wdt_keyed_counter.sv
`timescale 1ns/1ps
// Down-counter: loads 2^(BASE_SHIFT+code)-1 on start (initial code) or kick
// (normal code), and flags expiry when it sits at zero while enabled.
// Assumes BASE_SHIFT+15 < CNT_W.
module wdt_keyed_counter
    import wdt_keyed_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int BASE_SHIFT = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        start,
    input  logic        kick,
    input  range_code_t code_norm,
    input  range_code_t code_init,
    output logic        expire
);
    logic [CNT_W-1:0] cnt;

    function automatic logic [CNT_W-1:0] load_of(input range_code_t code);
        return (CNT_W'(1) << (BASE_SHIFT + int'(code))) - CNT_W'(1);
    endfunction

    // Expiry: zero count while running, unless a kick lands at this edge.
    always_comb expire = en && !kick && (cnt == '0);

    // Count down and reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= load_of(code_init);
        end else if (kick) begin
            cnt <= load_of(code_norm);
        end else if (en) begin
            if (cnt == '0) cnt <= load_of(code_norm);
            else           cnt <= cnt - CNT_W'(1);
        end
    end
endmodule

// File: rtl/wdt_keyed_resp.sv
`timescale 1ns/1ps
// Response stage: turns expiry events into the interrupt level and the
// fixed-length reset pulse. Assumes PULSE_W >= 1.
module wdt_keyed_resp #(
    parameter int PULSE_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode,
    input  logic expire,
    input  logic kick,
    output logic irq,
    output logic sys_rst
);
    localparam int PC_W = (PULSE_W > 1) ? $clog2(PULSE_W) : 1;

    logic            fire;
    logic [PC_W-1:0] pcnt;

    // Reset request: direct in reset mode, second strike in interrupt mode.
    always_comb fire = expire && (!mode || irq);

    // Interrupt level: set on first strike, cleared by a kick.
    always_ff @(posedge clk) begin
        if (!rst_n)                        irq <= 1'b0;
        else if (kick)                     irq <= 1'b0;
        else if (expire && mode && !irq)   irq <= 1'b1;
    end

    // Reset pulse of PULSE_W cycles; expiries during a pulse are absorbed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sys_rst <= 1'b0;
            pcnt    <= '0;
        end else if (fire && !sys_rst) begin
            sys_rst <= 1'b1;
            pcnt    <= PC_W'(PULSE_W - 1);
        end else if (sys_rst) begin
            if (pcnt == '0) sys_rst <= 1'b0;
            else            pcnt    <= pcnt - PC_W'(1);
        end
    end
endmodule

// File: rtl/wdt_keyed.sv
`timescale 1ns/1ps
// Top: keyed-restart watchdog. Register file, down-counter and response
// stage in series. Assumes a single clock domain and synchronous reset.
module wdt_keyed
    import wdt_keyed_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 32,
    parameter int BASE_SHIFT = 16,
    parameter int PULSE_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              sys_rst
);
    logic        ctrl_en, ctrl_mode, start, kick, expire;
    range_code_t code_norm, code_init;

    wdt_keyed_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .en(ctrl_en), .mode(ctrl_mode),
        .code_norm(code_norm), .code_init(code_init),
        .start(start), .kick(kick)
    );

    wdt_keyed_counter #(.CNT_W(CNT_W), .BASE_SHIFT(BASE_SHIFT)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(ctrl_en), .start(start), .kick(kick),
        .code_norm(code_norm), .code_init(code_init), .expire(expire)
    );

    wdt_keyed_resp #(.PULSE_W(PULSE_W)) u_resp (
        .clk(clk), .rst_n(rst_n), .mode(ctrl_mode), .expire(expire),
        .kick(kick), .irq(irq), .sys_rst(sys_rst)
    );
endmodule

// File: rtl/wdt_keyed_checker.sv
`timescale 1ns/1ps
// Checker: temporal properties of the watchdog, bound to the top.
module wdt_keyed_checker #(
    parameter int PULSE_W = 8
) (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic mode,
    input logic kick,
    input logic expire,
    input logic irq,
    input logic sys_rst
);
    logic [31:0] run_len;

    // Length of the current high run of sys_rst.
    always_ff @(posedge clk) begin
        if (!rst_n)       run_len <= '0;
        else if (sys_rst) run_len <= run_len + 32'd1;
        else              run_len <= '0;
    end

    p_pulse_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst) |-> run_len == 32'(PULSE_W));

    p_pulse_after_expiry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst) |-> $past(expire));

    p_en_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> en);

    p_mode_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> $stable(mode));

    p_kick_clears_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !irq);

    p_irq_needs_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (en && mode));

    p_quiet_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!irq && !sys_rst));
endmodule

bind wdt_keyed wdt_keyed_checker #(.PULSE_W(PULSE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en), .mode(ctrl_mode),
    .kick(kick), .expire(expire), .irq(irq), .sys_rst(sys_rst)
);

// File: tb/wdt_keyed_test.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected values at absolute cycles,
// a monitor pops and compares them at each falling edge.
module wdt_keyed_test;
    localparam int BASE = 4;
    localparam int PW   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, sys_rst;

    int cyc = 0;
    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    typedef struct { int at; int sig; logic [31:0] val; string tag; } exp_t;
    exp_t q[$];

    wdt_keyed #(.BASE_SHIFT(BASE), .PULSE_W(PW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sys_rst(sys_rst)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int per(int code);
        return 1 << (BASE + code);
    endfunction

    task automatic expect_at(int at, int sig, logic [31:0] val, string tag);
        exp_t e;
        e.at = at; e.sig = sig; e.val = val; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare every due entry.
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].at <= cyc) begin
                logic [31:0] act;
                act = (q[i].sig == 0) ? 32'(sys_rst) :
                      (q[i].sig == 1) ? 32'(irq) : bus_rdata;
                n_chk++;
                if (q[i].at != cyc || act !== q[i].val) begin
                    n_fail++;
                    $display("FAIL %s cyc %0d sig %0d actual %h expected %h",
                             q[i].tag, cyc, q[i].sig, act, q[i].val);
                end
                q.delete(i);
            end
        end
    end

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d, output int c);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1 c = cyc;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, input logic [31:0] e, input string tag);
        int c;
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); #1 c = cyc;
        expect_at(c, 2, e, tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
    endtask

    task automatic block_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_until(int at);
        while (cyc < at) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog timeout actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int c0, c1, k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values, R10 quiet while disabled
        expect_at(cyc + 1, 0, 0, "R1 sys_rst");
        expect_at(cyc + 1, 1, 0, "R1 irq");
        bus_read(4'h0, 32'h0, "R1 ctrl");
        bus_read(4'h4, 32'h0, "R1 range");
        bus_write(4'hC, 32'h76, c1);
        expect_at(c1 + 20, 0, 0, "R10 sys_rst off");
        expect_at(c1 + 60, 1, 0, "R10 irq off");
        drain();

        // Scenario A: reset mode, init code 2, normal code 1
        bus_write(4'h4, 32'hFFFF_FF21, c1);
        bus_read(4'h4, 32'h21, "R2 range readback");
        bus_write(4'h0, 32'h1, c0);
        expect_at(c0 + per(2) - 1, 0, 0, "R3 before first expiry");
        expect_at(c0 + per(2),     0, 1, "R3 first expiry");
        expect_at(c0 + per(2) + PW - 1, 0, 1, "R8 pulse last cycle");
        expect_at(c0 + per(2) + PW,     0, 0, "R8 pulse end");
        expect_at(c0 + per(2) + per(1) - 1, 0, 0, "R4 before reload expiry");
        expect_at(c0 + per(2) + per(1),     0, 1, "R4 reload expiry");
        expect_at(c0 + per(2) + per(1),     1, 0, "R8 no irq in reset mode");
        bus_write(4'h0, 32'h2, c1);
        bus_read(4'h0, 32'h1, "R7 ctrl locked");
        drain();
        block_reset();
        bus_read(4'h0, 32'h0, "R1 ctrl after reset");
        bus_read(4'h4, 32'h0, "R1 range after reset");
        drain();

        // Scenario B: keys, codes 0
        bus_write(4'h0, 32'h1, c0);
        bus_write(4'hC, 32'h75, c1);
        bus_write(4'hC, 32'h176, c1);
        expect_at(c0 + per(0) - 1, 0, 0, "R6 bad key no early");
        expect_at(c0 + per(0),     0, 1, "R6 bad key no delay");
        wait_until(c0 + 23);
        bus_write(4'hC, 32'h76, k);
        expect_at(c0 + 2 * per(0), 0, 0, "R5 kick cancels expiry");
        expect_at(k + per(0) - 1,  0, 0, "R5 before kicked expiry");
        expect_at(k + per(0),      0, 1, "R5 kicked expiry");
        drain();
        block_reset();

        // Scenario C: interrupt mode, codes 0
        bus_write(4'h0, 32'h3, c0);
        bus_write(4'h0, 32'h0, c1);
        bus_read(4'h0, 32'h3, "R7 mode and enable locked");
        expect_at(c0 + per(0) - 1, 1, 0, "R9 irq before expiry");
        expect_at(c0 + per(0),     1, 1, "R9 irq on first expiry");
        expect_at(c0 + per(0),     0, 0, "R9 no reset on first expiry");
        expect_at(c0 + 2 * per(0) - 1, 0, 0, "R9 no reset before second");
        expect_at(c0 + 2 * per(0),     0, 1, "R9 reset on second expiry");
        expect_at(c0 + 2 * per(0) + 4, 1, 1, "R9 irq held");
        wait_until(c0 + 37);
        bus_write(4'hC, 32'h76, k);
        expect_at(k,               1, 0, "R5 kick clears irq");
        expect_at(k + per(0) - 1,  1, 0, "R5 irq stays clear");
        expect_at(k + per(0),      1, 1, "R9 irq after kick period");
        expect_at(k + per(0),      0, 0, "R9 first strike after kick");
        drain();

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule